// File: doc/BRIEF.md
# Calendar Real-Time Clock with Register Access

This block keeps a wall-clock calendar: second, minute, hour, day of month, month, year within the century and century. When counting is enabled it moves forward one second on each cycle where `tick_i` is high. `tick_i` is normally a one-cycle pulse from a 1 Hz timebase. Month lengths are built in, and February gets 29 days in leap years. A year past 99 carries into the century field.

Software uses a plain 32-bit register port, made of a byte address, a write strobe with write data and a read strobe with read data. There is no valid/ready handshake, because the block is always ready. Every strobe completes in the cycle it is presented, and read data appears on the following cycle. The time is split across two packed words. A control register holds an enable bit, which starts and stops counting, and an unlock bit, which guards the two time words against stray writes. Two alarm locations are reserved in the map but have no function.

Top module: `cal_rtc`

## Requirements
- R1: After reset every readable location returns zero, counting is disabled and the time words are locked.
- R2: The time word at byte offset 0x00 holds day in bits 28:24, hour in 20:16, minute in 13:8 and second in 5:0. All other bits read as zero.
- R3: The date word at byte offset 0x04 holds century in bits 20:16, year within century (0 to 99) in bits 14:8 and month (1 to 12) in bits 3:0. All other bits read as zero. The full year is century × 100 + year.
- R4: Control at offset 0x10 is always writable. Bit 0 enables counting and bit 1 unlocks the time and date words. Reads return those two bits, and all higher bits read as zero.
- R5: A write to offset 0x00 or 0x04 while bit 1 of control is clear changes nothing.
- R6: With counting enabled, each cycle with `tick_i` high adds one second. Second and minute wrap from 59 to 0 and the hour wraps from 23 to 0, each carrying into the next field. A field already at or above its last value wraps on its next step.
- R7: The day wraps to 1 after the last day of the month. April, June, September and November have 30 days and February has 28. February has 29 days when the full year is divisible by 4 and not by 100, or is divisible by 400. Month wraps from 12 to 1 and carries into the year.
- R8: Year wraps from 99 to 0 and increments the century.
- R9: With counting disabled, ticks are ignored and reads of the time and date words return the value last stored.
- R10: Offsets 0x08, 0x0C and 0x14 read as zero, and writes to them alter no other register.
- R11: An accepted write to a time or date word loads all of that word's fields at once. A tick in the same cycle is dropped. A write rejected because the words are locked does not block the tick.
- R12: `bus_rdata` takes the addressed value on the cycle after `bus_rd` is high, using the state from before that edge. It holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second advance pulse |
| bus_addr | input | ADDR_W (5) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |

## Verification
All state is visible through the two packed words, so a wrong counter or carry shows up on the first read after the tick that caused it. Wrong month-length or leap logic stays hidden until a day-28, 29, 30 or 31 boundary is crossed. For that reason the directed cases load the time a single second before each such boundary and read it back after one tick. A fault in the lock or enable bit shows up on the next read of a word that should have stayed unchanged.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int DATA_W = 32;
  // word indices (byte offset / 4); the offsets are part of the software contract
  localparam int IDX_TIME  = 0;
  localparam int IDX_DATE  = 1;
  localparam int IDX_ALM   = 2;
  localparam int IDX_CTL   = 4;
  localparam int IDX_ALMST = 5;

  typedef struct packed {
    logic [4:0] cent;
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] day;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  function automatic logic [DATA_W-1:0] pack_time(cal_time_t t);
    return {3'b0, t.day, 3'b0, t.hr, 2'b0, t.min, 2'b0, t.sec};
  endfunction

  function automatic logic [DATA_W-1:0] pack_date(cal_time_t t);
    return {11'b0, t.cent, 1'b0, t.yr, 4'b0, t.mon};
  endfunction
endpackage

// File: rtl/cal_rtc_digit.sv
module cal_rtc_digit #(
  parameter int W     = 6,
  parameter int FIRST = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic [W-1:0] last_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] FIRST_V = W'(FIRST);
  logic wrap;

  assign wrap    = (val_o >= last_i);
  assign carry_o = step_i && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)       val_o <= '0;
    else if (load_i)  val_o <= load_val_i;
    else if (step_i)  val_o <= wrap ? FIRST_V : val_o + 1'b1;
  end

  // R6
  wrap_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (val_o >= last_i)) |=> (val_o == FIRST_V));

  // R6
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && (val_o < last_i)) |=> (val_o == $past(val_o) + 1'b1));
endmodule

// File: rtl/cal_rtc_mlen.sv
module cal_rtc_mlen (
  input  logic [3:0] mon_i,
  input  logic [6:0] yr_i,
  input  logic [4:0] cent_i,
  output logic [4:0] last_day_o
);
  logic leap;

  // with yr below 100: years not ending in 00 follow yr mod 4, the 00 years follow the century mod 4
  assign leap = (yr_i != 7'd0) ? (yr_i[1:0] == 2'b00) : (cent_i[1:0] == 2'b00);

  always_comb begin
    case (mon_i)
      4'd2:                    last_day_o = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: last_day_o = 5'd30;
      default:                 last_day_o = 5'd31;
    endcase
  end
endmodule

// File: rtl/cal_rtc_core.sv
module cal_rtc_core
  import cal_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              ld_time_i,
  input  logic              ld_date_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cal_time_t         time_o
);
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr, c_cent;
  logic [4:0] last_day;

  cal_rtc_digit #(.W(6), .FIRST(0)) u_sec (
    .clk, .rst_n, .step_i(step_i), .last_i(6'd59),
    .load_i(ld_time_i), .load_val_i(wdata_i[5:0]),
    .val_o(time_o.sec), .carry_o(c_sec));

  cal_rtc_digit #(.W(6), .FIRST(0)) u_min (
    .clk, .rst_n, .step_i(c_sec), .last_i(6'd59),
    .load_i(ld_time_i), .load_val_i(wdata_i[13:8]),
    .val_o(time_o.min), .carry_o(c_min));

  cal_rtc_digit #(.W(5), .FIRST(0)) u_hr (
    .clk, .rst_n, .step_i(c_min), .last_i(5'd23),
    .load_i(ld_time_i), .load_val_i(wdata_i[20:16]),
    .val_o(time_o.hr), .carry_o(c_hr));

  cal_rtc_mlen u_mlen (
    .mon_i(time_o.mon), .yr_i(time_o.yr), .cent_i(time_o.cent),
    .last_day_o(last_day));

  cal_rtc_digit #(.W(5), .FIRST(1)) u_day (
    .clk, .rst_n, .step_i(c_hr), .last_i(last_day),
    .load_i(ld_time_i), .load_val_i(wdata_i[28:24]),
    .val_o(time_o.day), .carry_o(c_day));

  cal_rtc_digit #(.W(4), .FIRST(1)) u_mon (
    .clk, .rst_n, .step_i(c_day), .last_i(4'd12),
    .load_i(ld_date_i), .load_val_i(wdata_i[3:0]),
    .val_o(time_o.mon), .carry_o(c_mon));

  cal_rtc_digit #(.W(7), .FIRST(0)) u_yr (
    .clk, .rst_n, .step_i(c_mon), .last_i(7'd99),
    .load_i(ld_date_i), .load_val_i(wdata_i[14:8]),
    .val_o(time_o.yr), .carry_o(c_yr));

  cal_rtc_digit #(.W(5), .FIRST(0)) u_cent (
    .clk, .rst_n, .step_i(c_yr), .last_i(5'd31),
    .load_i(ld_date_i), .load_val_i(wdata_i[20:16]),
    .val_o(time_o.cent), .carry_o(c_cent));

  // R9
  frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !ld_time_i && !ld_date_i) |=> $stable(time_o));

  // R8
  century_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_yr && !ld_date_i) |=> (time_o.yr == 7'd0));
endmodule

// File: rtl/cal_rtc_regs.sv
module cal_rtc_regs
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  cal_time_t         time_i,
  output logic              step_o,
  output logic              ld_time_o,
  output logic              ld_date_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] I_TIME = IDX_W'(IDX_TIME);
  localparam logic [IDX_W-1:0] I_DATE = IDX_W'(IDX_DATE);
  localparam logic [IDX_W-1:0] I_ALM  = IDX_W'(IDX_ALM);
  localparam logic [IDX_W-1:0] I_CTL  = IDX_W'(IDX_CTL);
  localparam logic [IDX_W-1:0] I_ALMS = IDX_W'(IDX_ALMST);

  logic [IDX_W-1:0]  idx;
  logic              run_q, unlock_q;
  logic [DATA_W-1:0] rd_val;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign ld_time_o = bus_wr && (idx == I_TIME) && unlock_q;
  assign ld_date_o = bus_wr && (idx == I_DATE) && unlock_q;
  assign step_o    = tick_i && run_q && !(ld_time_o || ld_date_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      unlock_q <= 1'b0;
    end else if (bus_wr && (idx == I_CTL)) begin
      run_q    <= bus_wdata[0];
      unlock_q <= bus_wdata[1];
    end
  end

  always_comb begin
    case (idx)
      I_TIME:  rd_val = pack_time(time_i);
      I_DATE:  rd_val = pack_date(time_i);
      I_CTL:   rd_val = {{(DATA_W-2){1'b0}}, unlock_q, run_q};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  // R10
  alarm_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ((idx == I_ALM) || (idx == I_ALMS))) |=> (bus_rdata == '0));

  // R5
  locked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (idx == I_TIME) && !unlock_q && !(tick_i && run_q))
      |=> $stable(pack_time(time_i)));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  cal_time_t now;
  logic      step, ld_time, ld_date;

  cal_rtc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk, .rst_n, .tick_i,
    .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata,
    .time_i(now), .step_o(step), .ld_time_o(ld_time), .ld_date_o(ld_date));

  cal_rtc_core u_core (
    .clk, .rst_n, .step_i(step), .ld_time_i(ld_time), .ld_date_i(ld_date),
    .wdata_i(bus_wdata), .time_o(now));

  // R11
  write_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_time && tick_i) |=> (pack_time(now) == ($past(bus_wdata) & 32'h1F1F3F3F)));
endmodule

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cal_rtc u_dut (.clk, .rst_n, .tick_i, .bus_addr, .bus_wr, .bus_wdata, .bus_rd, .bus_rdata);

  // behavioural reference
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_cent, m_run, m_unl;
  logic [31:0] m_rdata;

  function automatic int mdays(int mon, int full);
    bit lp = ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
    if (mon == 2) return lp ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] m_read(int a);
    case (a >> 2)
      0: return 32'((m_day << 24) | (m_hr << 16) | (m_min << 8) | m_sec);
      1: return 32'((m_cent << 16) | (m_yr << 8) | m_mon);
      4: return 32'((m_unl << 1) | m_run);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      {m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_cent, m_run, m_unl} = '{default: 0};
      m_rdata = '0;
    end else begin
      bit ld;
      bit adv;
      ld = bus_wr && m_unl != 0 && (bus_addr[4:2] == 0 || bus_addr[4:2] == 1);
      adv = tick_i && m_run != 0 && !ld;
      if (bus_rd) m_rdata = m_read(int'(bus_addr));
      if (adv) begin
        if (m_sec >= 59) begin
          m_sec = 0;
          if (m_min >= 59) begin
            m_min = 0;
            if (m_hr >= 23) begin
              m_hr = 0;
              if (m_day >= mdays(m_mon, m_cent * 100 + m_yr)) begin
                m_day = 1;
                if (m_mon >= 12) begin
                  m_mon = 1;
                  if (m_yr >= 99) begin m_yr = 0; m_cent = (m_cent + 1) % 32; end
                  else m_yr++;
                end else m_mon++;
              end else m_day++;
            end else m_hr++;
          end else m_min++;
        end else m_sec++;
      end
      if (bus_wr) begin
        if (bus_addr[4:2] == 4) begin
          m_run = int'(bus_wdata[0]);
          m_unl = int'(bus_wdata[1]);
        end else if (ld && bus_addr[4:2] == 0) begin
          m_day = int'(bus_wdata[28:24]); m_hr = int'(bus_wdata[20:16]);
          m_min = int'(bus_wdata[13:8]);  m_sec = int'(bus_wdata[5:0]);
        end else if (ld) begin
          m_cent = int'(bus_wdata[20:16]); m_yr = int'(bus_wdata[14:8]);
          m_mon = int'(bus_wdata[3:0]);
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (bus_rdata !== m_rdata) begin
        bad++;
        $display("FAIL %s model: got=%h exp=%h t=%0t", cur_req, bus_rdata, m_rdata, $time);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cycle(input logic [4:0] a, input logic w, input logic [31:0] d,
                       input logic r, input logic t);
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r; tick_i = t;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; tick_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cycle(a, 1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic chk_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    cycle(a, 1'b0, 32'h0, 1'b1, 1'b0);
    total++;
    if (bus_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h: got=%h exp=%h", tag, a, bus_rdata, exp);
    end
  endtask

  task automatic boundary(input logic [31:0] tw, input logic [31:0] dw,
                          input logic [31:0] et, input logic [31:0] ed, input string tag);
    wr(5'h10, 32'h2);
    wr(5'h00, tw);
    wr(5'h04, dw);
    wr(5'h10, 32'h3);
    cycle(5'h00, 1'b0, 32'h0, 1'b0, 1'b1);
    chk_rd(5'h00, et, tag);
    chk_rd(5'h04, ed, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    chk_rd(5'h00, 32'h0, "R1");
    chk_rd(5'h04, 32'h0, "R1");
    chk_rd(5'h10, 32'h0, "R1");

    cur_req = "R4";
    wr(5'h10, 32'hFFFFFFFF);
    chk_rd(5'h10, 32'h3, "R4");
    wr(5'h10, 32'h0);
    chk_rd(5'h10, 32'h0, "R4");

    cur_req = "R5";
    wr(5'h00, 32'h12345678);
    wr(5'h04, 32'h00141802);
    chk_rd(5'h00, 32'h0, "R5");
    chk_rd(5'h04, 32'h0, "R5");

    cur_req = "R2";
    wr(5'h10, 32'h2);
    wr(5'h00, 32'hFFFFFFFF);
    chk_rd(5'h00, 32'h1F1F3F3F, "R2");
    cur_req = "R3";
    wr(5'h04, 32'hFFFFFFFF);
    chk_rd(5'h04, 32'h001F7F0F, "R3");

    cur_req = "R7";
    boundary(32'h1C173B3B, 32'h00141802, 32'h1D000000, 32'h00141802, "R7 leap 2024");
    boundary(32'h1C173B3B, 32'h00141702, 32'h01000000, 32'h00141703, "R7 plain 2023");
    boundary(32'h1C173B3B, 32'h00140002, 32'h1D000000, 32'h00140002, "R7 leap 2000");
    boundary(32'h1C173B3B, 32'h00150002, 32'h01000000, 32'h00150003, "R7 plain 2100");
    boundary(32'h1E173B3B, 32'h00141804, 32'h01000000, 32'h00141805, "R7 april");
    cur_req = "R8";
    boundary(32'h1F173B3B, 32'h0014630C, 32'h01000000, 32'h00150001, "R8 century");

    cur_req = "R6";
    wr(5'h10, 32'h2);
    wr(5'h00, 32'h050A3A1E);
    wr(5'h10, 32'h3);
    for (int i = 0; i < 40; i++) cycle(5'h00, 1'b0, 32'h0, 1'b0, 1'b1);
    chk_rd(5'h00, 32'h050A3B0A, "R6");

    cur_req = "R9";
    wr(5'h10, 32'h2);
    for (int i = 0; i < 5; i++) cycle(5'h00, 1'b0, 32'h0, 1'b0, 1'b1);
    chk_rd(5'h00, 32'h050A3B0A, "R9");

    cur_req = "R10";
    wr(5'h08, 32'hFFFFFFFF);
    wr(5'h14, 32'hFFFFFFFF);
    wr(5'h0C, 32'hFFFFFFFF);
    chk_rd(5'h08, 32'h0, "R10");
    chk_rd(5'h14, 32'h0, "R10");
    chk_rd(5'h0C, 32'h0, "R10");
    chk_rd(5'h10, 32'h2, "R10");
    chk_rd(5'h00, 32'h050A3B0A, "R10");

    cur_req = "R11";
    wr(5'h10, 32'h3);
    cycle(5'h00, 1'b1, 32'h01020304, 1'b0, 1'b1);
    chk_rd(5'h00, 32'h01020304, "R11 accepted");
    wr(5'h10, 32'h1);
    cycle(5'h00, 1'b1, 32'h1F1F1F1F, 1'b0, 1'b1);
    chk_rd(5'h00, 32'h01020305, "R11 locked");

    cur_req = "R12";
    chk_rd(5'h00, 32'h01020305, "R12");
    for (int i = 0; i < 3; i++) cycle(5'h00, 1'b0, 32'h0, 1'b0, 1'b1);
    total++;
    if (bus_rdata !== 32'h01020305) begin
      bad++;
      $display("FAIL R12 hold: got=%h exp=%h", bus_rdata, 32'h01020305);
    end
    chk_rd(5'h00, 32'h01020308, "R12");

    cur_req = "R6 R7 R9 random";
    wr(5'h10, 32'h2);
    wr(5'h00, 32'h1C173A00);
    wr(5'h04, 32'h00146302);
    wr(5'h10, 32'h3);
    for (int i = 0; i < 6000; i++) begin
      logic [4:0] a;
      case ($urandom_range(0, 4))
        0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3: a = 5'h10; default: a = 5'h14;
      endcase
      if ($urandom_range(0, 199) == 0)
        cycle(5'h10, 1'b1, {30'h0, 1'b1, ($urandom_range(0, 3) != 0)}, 1'b0, 1'b1);
      else
        cycle(a, 1'b0, 32'h0, $urandom_range(0, 1) == 1, 1'b1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule